// File: doc/BRIEF.md
# Serial Word Transmitter

This block sends 32-bit words from a host over a single serial line. The host can load a word in two halves, each with its own strobe, or the block can fetch whole words from an external FIFO through a read handshake. A ready flag shows when the input latch can take a word. Because the input latch and the shift register are separate, the host can load the next word while the current one is still being sent.

A word goes out as a frame: a sync bit, a word-identifier bit, the 32 data bits, and a parity bit if parity is enabled. The block can also send short control frames of three or four bits, which are loaded on their own strobe. In burst mode, words that are loaded while a word is being sent are added to the same frame without a new header. The line output is either NRZ data with a shift clock or Manchester data with its complement. An envelope output is high while a frame is on the line. A loopback input sends the transmit pair to the receive-side outputs in place of the external receive inputs.

Top module: `txs_word_tx`

## Requirements
- R1: A cycle with `str_lo` high latches `bus_i[15:0]` as the lower half. A cycle with `str_hi` high latches `bus_i[31:16]` and `wi_i`, and `ready_o` is 0 after that edge. While `ready_o` is 0, both strobes are ignored: the word already latched is the one that is sent, and no extra frame appears.
- R2: When the transmitter is idle, `ready_o` returns to 1 on the clock edge after the edge that latched the upper half, and `env_o` rises on the edge after that.
- R3: A word frame is sent in this order: a sync bit of 1, the word-identifier bit, the data bits from bit 31 down to bit 0, and then a parity bit when `par_en` is 1. The frame is 34 bits long without parity and 35 bits long with it.
- R4: The parity bit is computed over the 32 data bits only. With `par_odd`=1 the number of ones across the data and parity is odd. With `par_odd`=0 it is even.
- R5: Each bit lasts 2 clocks. With `man_sel`=0, `tx_a_o` carries the bit value in both clocks, and `tx_b_o` is 0 in the first clock and 1 in the second.
- R6: With `man_sel`=1, `tx_a_o` carries the bit in the first clock and its inverse in the second, so a 1 is sent as high then low. `tx_b_o` is always the complement of `tx_a_o`.
- R7: `env_o` stays high for exactly 2×N consecutive clocks, where N is the number of bits in the frame. While `env_o` is 0, both `tx_a_o` and `tx_b_o` are 0. Frames sent without burst are separated by at least one clock with `env_o` low.
- R8: A cycle with `ctl_ld` high captures `ctl_data`, `ctl_cmd` and `ctl_bit4`. The resulting control frame is sync 1, then the data bit, then the command bit, then the bit-four value when `type_e`=1. The frame is 3 bits long when `type_e`=0 and 4 bits long when `type_e`=1.
- R9: A control frame never interrupts a word frame already on the line; it waits until that frame ends. If a control frame and a latched word are both waiting while the transmitter is idle, the control frame is sent first. A `ctl_ld` pulse that arrives while a control frame is already waiting is ignored.
- R10: With `burst`=1, the first word starts with sync and its word-identifier bit. Any word that is latched before the last bit of the current word finishes is sent straight after it, as 32 data bits plus its parity bit, with no sync or identifier bit. `env_o` stays high across the joined words.
- R11: With `fifo_en`=1 and the latch free, `fifo_rd_n` goes low for exactly one clock. The `bus_i` and `wi_i` values present during that clock are latched as the next word. No read pulse is issued while the latch holds a word.
- R12: With `loop_en`=1, `rx_data_o` follows `tx_a_o` and `rx_clk_o` follows `tx_b_o`. With `loop_en`=0, they follow `rx_data_i` and `rx_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| str_lo | input | 1 | Lower-half load strobe |
| str_hi | input | 1 | Upper-half load strobe; completes the word |
| bus_i | input | 32 | Host data bus / FIFO data |
| wi_i | input | 1 | Word-identifier bit (0 data, 1 command) |
| par_en | input | 1 | Append a parity bit to each word |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| burst | input | 1 | Join queued words into one frame |
| fifo_en | input | 1 | Fetch words automatically through the FIFO handshake |
| fifo_rd_n | output | 1 | Active-low FIFO read pulse |
| ready_o | output | 1 | Input latch free |
| ctl_ld | input | 1 | Control frame load strobe |
| ctl_data | input | 1 | Control frame data bit |
| ctl_cmd | input | 1 | Control frame command bit |
| ctl_bit4 | input | 1 | Fourth control bit, used only for four-bit frames |
| type_e | input | 1 | 1 selects four-bit control frames, 0 selects three-bit frames |
| man_sel | input | 1 | 1 selects Manchester output, 0 selects NRZ with a clock |
| loop_en | input | 1 | Route the transmit pair to the receive-side outputs |
| rx_data_i | input | 1 | External receive data |
| rx_clk_i | input | 1 | External receive clock |
| env_o | output | 1 | Envelope, high while a frame is on the line |
| tx_a_o | output | 1 | NRZ data or Manchester data |
| tx_b_o | output | 1 | Shift clock or inverted Manchester data |
| rx_data_o | output | 1 | Receive data toward the receiver |
| rx_clk_o | output | 1 | Receive clock toward the receiver |

## Verification
The hardest situation to reach from the ports is a crowded queue. In it, a control request, a second control request and two host words all arrive while a word frame is on the line. The bench builds this by loading requests as soon as `env_o` rises and `ready_o` returns. It then checks the order of the frames, that the second control request was dropped, and that the strobe made while the latch was full had no effect. Burst joining needs each later word to land inside a narrow window before the previous word ends. The bench meets this by loading on the first cycle `ready_o` shows free. The FIFO path is driven by a bench responder that places a new word on the bus in each cycle where the read pulse is low.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} tx_state_t;

  typedef struct packed {
    logic data;
    logic cmd;
    logic bit4;
  } ctl_bits_t;
endpackage

// File: rtl/txs_in_latch.sv
module txs_in_latch #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              str_lo,
  input  logic              str_hi,
  input  logic [WORD_W-1:0] bus_i,
  input  logic              wi_i,
  input  logic              fifo_en,
  input  logic              take_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wi_o,
  output logic              free_o,
  output logic              rd_n_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic              wi_q, free_q, rd_n_q;

  // data halves carry no reset so they map onto plain registers
  always_ff @(posedge clk) begin
    if (!rd_n_q && !take_i) begin
      lo_q <= bus_i[HALF_W-1:0];
      hi_q <= bus_i[WORD_W-1:HALF_W];
      wi_q <= wi_i;
    end else if (!fifo_en && free_q) begin
      if (str_lo) lo_q <= bus_i[HALF_W-1:0];
      if (str_hi) begin
        hi_q <= bus_i[WORD_W-1:HALF_W];
        wi_q <= wi_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      rd_n_q <= !(fifo_en && free_q && rd_n_q);
      if (take_i)
        free_q <= 1'b1;
      else if (!rd_n_q)
        free_q <= 1'b0;
      else if (!fifo_en && free_q && str_hi)
        free_q <= 1'b0;
    end
  end

  assign word_o = {hi_q, lo_q};
  assign wi_o   = wi_q;
  assign free_o = free_q;
  assign rd_n_o = rd_n_q;
endmodule

// File: rtl/txs_ctl_hold.sv
module txs_ctl_hold
  import txs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ld_i,
  input  logic      data_i,
  input  logic      cmd_i,
  input  logic      bit4_i,
  input  logic      take_i,
  output logic      pend_o,
  output ctl_bits_t bits_o
);
  logic      pend_q;
  ctl_bits_t bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      bits_q <= '0;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end else if (ld_i && !pend_q) begin
      pend_q      <= 1'b1;
      bits_q.data <= data_i;
      bits_q.cmd  <= cmd_i;
      bits_q.bit4 <= bit4_i;
    end
  end

  assign pend_o = pend_q;
  assign bits_o = bits_q;
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer
  import txs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wi_i,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              burst,
  input  logic              type_e,
  input  logic              ctl_pend_i,
  input  ctl_bits_t         ctl_i,
  output logic              take_word_o,
  output logic              take_ctl_o,
  output logic              sending_o,
  output logic              bit_o,
  output logic              ph_o
);
  localparam int SH_W  = WORD_W + 3;
  localparam int CNT_W = $clog2(SH_W + 1);

  tx_state_t        state_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q, is_ctl_q;

  logic             par_bit, start_ctl, start_word, last_bit, chain;
  logic [SH_W-1:0]  hdr_vec, chain_vec, ctl_vec;
  logic [CNT_W-1:0] hdr_len, chain_len, ctl_len, pe_ext, te_ext;

  assign par_bit   = par_en & (par_odd ? ~^word_i : ^word_i);
  assign hdr_vec   = {1'b1, wi_i, word_i, par_bit};
  assign chain_vec = {word_i, par_bit, 2'b00};
  assign ctl_vec   = {1'b1, ctl_i.data, ctl_i.cmd, ctl_i.bit4 & type_e, {(SH_W-4){1'b0}}};
  assign pe_ext    = {{(CNT_W-1){1'b0}}, par_en};
  assign te_ext    = {{(CNT_W-1){1'b0}}, type_e};
  assign hdr_len   = CNT_W'(WORD_W + 2) + pe_ext;
  assign chain_len = CNT_W'(WORD_W) + pe_ext;
  assign ctl_len   = CNT_W'(3) + te_ext;

  assign start_ctl  = (state_q == ST_IDLE) && ctl_pend_i;
  assign start_word = (state_q == ST_IDLE) && !ctl_pend_i && full_i;
  assign last_bit   = (state_q == ST_SEND) && ph_q && (cnt_q == CNT_W'(1));
  assign chain      = last_bit && !is_ctl_q && burst && full_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      ph_q     <= 1'b0;
      is_ctl_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          ph_q <= 1'b0;
          if (start_ctl) begin
            sh_q     <= ctl_vec;
            cnt_q    <= ctl_len;
            is_ctl_q <= 1'b1;
            state_q  <= ST_SEND;
          end else if (start_word) begin
            sh_q     <= hdr_vec;
            cnt_q    <= hdr_len;
            is_ctl_q <= 1'b0;
            state_q  <= ST_SEND;
          end
        end
        default: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (cnt_q == CNT_W'(1)) begin
              if (chain) begin
                sh_q  <= chain_vec;
                cnt_q <= chain_len;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              sh_q  <= sh_q << 1;
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign take_word_o = start_word || chain;
  assign take_ctl_o  = start_ctl;
  assign sending_o   = (state_q == ST_SEND);
  assign bit_o       = sh_q[SH_W-1];
  assign ph_o        = ph_q;
endmodule

// File: rtl/txs_line_enc.sv
module txs_line_enc #(
  parameter bit LOOPBACK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sending_i,
  input  logic bit_i,
  input  logic ph_i,
  input  logic man_sel,
  input  logic loop_en,
  input  logic rx_data_i,
  input  logic rx_clk_i,
  output logic env_o,
  output logic tx_a_o,
  output logic tx_b_o,
  output logic rx_data_o,
  output logic rx_clk_o
);
  logic env_q, a_q, b_q, man_bit;

  assign man_bit = bit_i ^ ph_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      env_q <= 1'b0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end else begin
      env_q <= sending_i;
      a_q   <= sending_i & (man_sel ? man_bit : bit_i);
      b_q   <= sending_i & (man_sel ? ~man_bit : ph_i);
    end
  end

  assign env_o  = env_q;
  assign tx_a_o = a_q;
  assign tx_b_o = b_q;

  generate
    if (LOOPBACK_EN) begin : g_loop
      assign rx_data_o = loop_en ? a_q : rx_data_i;
      assign rx_clk_o  = loop_en ? b_q : rx_clk_i;
    end else begin : g_pass
      logic unused_loop;
      assign unused_loop = loop_en;
      assign rx_data_o   = rx_data_i;
      assign rx_clk_o    = rx_clk_i;
    end
  endgenerate
endmodule

// File: rtl/txs_word_tx.sv
module txs_word_tx
  import txs_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter bit LOOPBACK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              str_lo,
  input  logic              str_hi,
  input  logic [WORD_W-1:0] bus_i,
  input  logic              wi_i,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              burst,
  input  logic              fifo_en,
  output logic              fifo_rd_n,
  output logic              ready_o,
  input  logic              ctl_ld,
  input  logic              ctl_data,
  input  logic              ctl_cmd,
  input  logic              ctl_bit4,
  input  logic              type_e,
  input  logic              man_sel,
  input  logic              loop_en,
  input  logic              rx_data_i,
  input  logic              rx_clk_i,
  output logic              env_o,
  output logic              tx_a_o,
  output logic              tx_b_o,
  output logic              rx_data_o,
  output logic              rx_clk_o
);
  logic [WORD_W-1:0] word;
  logic              wi, free, take_word, take_ctl, ctl_pend, sending, bit_v, ph;
  ctl_bits_t         ctl_bits;

  txs_in_latch #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .rst(rst), .str_lo(str_lo), .str_hi(str_hi), .bus_i(bus_i),
    .wi_i(wi_i), .fifo_en(fifo_en), .take_i(take_word), .word_o(word),
    .wi_o(wi), .free_o(free), .rd_n_o(fifo_rd_n)
  );

  txs_ctl_hold u_ctl (
    .clk(clk), .rst(rst), .ld_i(ctl_ld), .data_i(ctl_data), .cmd_i(ctl_cmd),
    .bit4_i(ctl_bit4), .take_i(take_ctl), .pend_o(ctl_pend), .bits_o(ctl_bits)
  );

  txs_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst(rst), .full_i(!free), .word_i(word), .wi_i(wi),
    .par_en(par_en), .par_odd(par_odd), .burst(burst), .type_e(type_e),
    .ctl_pend_i(ctl_pend), .ctl_i(ctl_bits), .take_word_o(take_word),
    .take_ctl_o(take_ctl), .sending_o(sending), .bit_o(bit_v), .ph_o(ph)
  );

  txs_line_enc #(.LOOPBACK_EN(LOOPBACK_EN)) u_enc (
    .clk(clk), .rst(rst), .sending_i(sending), .bit_i(bit_v), .ph_i(ph),
    .man_sel(man_sel), .loop_en(loop_en), .rx_data_i(rx_data_i),
    .rx_clk_i(rx_clk_i), .env_o(env_o), .tx_a_o(tx_a_o), .tx_b_o(tx_b_o),
    .rx_data_o(rx_data_o), .rx_clk_o(rx_clk_o)
  );

  assign ready_o = free;
endmodule

// File: rtl/txs_word_tx_chk.sv
module txs_word_tx_chk (
  input logic clk,
  input logic rst,
  input logic str_hi,
  input logic fifo_en,
  input logic ready_o,
  input logic env_o,
  input logic tx_a_o,
  input logic tx_b_o,
  input logic man_sel,
  input logic fifo_rd_n
);
  p_load_drops_ready_r1: assert property (@(posedge clk) disable iff (rst)
    str_hi && ready_o && !fifo_en |=> !ready_o);

  p_env_follows_take_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) && !env_o |=> env_o);

  p_nrz_clock_toggles_r5: assert property (@(posedge clk) disable iff (rst)
    env_o && $past(env_o) && !$past(man_sel) && !$past(man_sel, 2) |-> tx_b_o != $past(tx_b_o));

  p_man_complement_r6: assert property (@(posedge clk) disable iff (rst)
    env_o && $past(man_sel) |-> tx_b_o == !tx_a_o);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !env_o |-> !tx_a_o && !tx_b_o);

  p_fifo_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    !fifo_rd_n |=> fifo_rd_n);

  p_fifo_when_free_r11: assert property (@(posedge clk) disable iff (rst)
    !fifo_rd_n |-> ready_o);
endmodule

bind txs_word_tx txs_word_tx_chk u_chk (
  .clk(clk), .rst(rst), .str_hi(str_hi), .fifo_en(fifo_en), .ready_o(ready_o),
  .env_o(env_o), .tx_a_o(tx_a_o), .tx_b_o(tx_b_o), .man_sel(man_sel),
  .fifo_rd_n(fifo_rd_n)
);

// File: tb/tb_txs_word_tx.sv
`timescale 1ns/1ps
module tb_txs_word_tx;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic str_lo = 0, str_hi = 0, wi_i = 0, par_en = 0, par_odd = 0, burst = 0, fifo_en = 0;
  logic ctl_ld = 0, ctl_data = 0, ctl_cmd = 0, ctl_bit4 = 0, type_e = 0, man_sel = 0;
  logic loop_en = 0, rx_data_i = 0, rx_clk_i = 0;
  logic [W-1:0] bus_i = '0;
  logic fifo_rd_n, ready_o, env_o, tx_a_o, tx_b_o, rx_data_o, rx_clk_o;

  txs_word_tx #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .str_lo(str_lo), .str_hi(str_hi), .bus_i(bus_i), .wi_i(wi_i),
    .par_en(par_en), .par_odd(par_odd), .burst(burst), .fifo_en(fifo_en),
    .fifo_rd_n(fifo_rd_n), .ready_o(ready_o), .ctl_ld(ctl_ld), .ctl_data(ctl_data),
    .ctl_cmd(ctl_cmd), .ctl_bit4(ctl_bit4), .type_e(type_e), .man_sel(man_sel),
    .loop_en(loop_en), .rx_data_i(rx_data_i), .rx_clk_i(rx_clk_i), .env_o(env_o),
    .tx_a_o(tx_a_o), .tx_b_o(tx_b_o), .rx_data_o(rx_data_o), .rx_clk_o(rx_clk_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // frame capture at the falling edge
  logic cap_a [0:255];
  logic cap_b [0:255];
  int cn = 0, flen = 0, done_cnt = 0, seen_done = 0;
  logic prev_env = 0;

  always @(negedge clk) begin
    if (env_o) begin
      if (!prev_env) cn = 0;
      if (cn < 256) begin cap_a[cn] = tx_a_o; cap_b[cn] = tx_b_o; end
      cn++;
    end else if (prev_env) begin
      flen = cn;
      done_cnt++;
    end
    prev_env = env_o;
  end

  logic ex [0:127];
  int en = 0;

  task automatic ex_clear(); en = 0; endtask
  task automatic ex_push(input logic b); ex[en] = b; en++; endtask
  task automatic ex_word(input logic [W-1:0] w, input logic pe, input logic po);
    for (int i = W-1; i >= 0; i--) ex_push(w[i]);
    if (pe) ex_push(po ? ~^w : ^w);
  endtask

  task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_frame(input string tag);
    int bad = -1;
    logic ea, eb;
    checks++;
    if (flen != 2*en) begin
      fails++;
      $display("FAIL %s frame length actual=%0d expected=%0d samples", tag, flen, 2*en);
      return;
    end
    for (int s = 0; s < flen && bad < 0; s++) begin
      if (man_sel) begin ea = (s % 2 == 0) ? ex[s/2] : ~ex[s/2]; eb = ~ea; end
      else begin ea = ex[s/2]; eb = (s % 2 == 1); end
      if (cap_a[s] !== ea || cap_b[s] !== eb) begin
        bad = s;
        fails++;
        $display("FAIL %s sample %0d actual a=%b b=%b expected a=%b b=%b",
                 tag, s, cap_a[s], cap_b[s], ea, eb);
      end
    end
  endtask

  task automatic wait_frame(input string tag);
    int t = 0;
    while (done_cnt == seen_done && t < 3000) begin @(posedge clk); t++; end
    if (done_cnt == seen_done) begin
      checks++; fails++;
      $display("FAIL %s no frame actual=0 expected=1", tag);
    end
    seen_done = done_cnt;
  endtask

  task automatic send_word(input logic [W-1:0] w, input logic wi);
    @(negedge clk);
    bus_i = w; wi_i = wi; str_lo = 1; str_hi = 1;
    @(negedge clk);
    str_lo = 0; str_hi = 0;
  endtask

  task automatic wait_ready();
    int t = 0;
    while (!ready_o && t < 3000) begin @(negedge clk); t++; end
  endtask

  function automatic logic [W-1:0] fifo_word(input int k);
    return 32'hC0DE_0000 + k * 32'h0101_0F0F;
  endfunction

  initial begin
    logic [W-1:0] wa, wb, wc;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check1("R1 reset ready", ready_o, 1);
    check1("R7 reset env", env_o, 0);
    check1("R7 reset tx pair", {tx_a_o, tx_b_o}, 0);
    check1("R11 reset fifo read", fifo_rd_n, 1);

    // R1 R2: split loading and start timing
    par_en = 1; par_odd = 1; man_sel = 0;
    @(negedge clk);
    bus_i = 32'h1234_ABCD; str_lo = 1;
    @(negedge clk);
    check1("R1 ready after lower half", ready_o, 1);
    str_lo = 0; bus_i = 32'h5678_0000; wi_i = 1; str_hi = 1;
    @(negedge clk);
    str_hi = 0;
    check1("R1 ready low after upper half", ready_o, 0);
    @(negedge clk);
    check1("R2 ready back, env still low", {ready_o, env_o}, 2'b10);
    @(negedge clk);
    check1("R2 env rises", env_o, 1);
    wait_frame("R3 split load");
    ex_clear(); ex_push(1); ex_push(1); ex_word(32'h5678_ABCD, 1, 1);
    check_frame("R1 R3 split-loaded word");

    // R3 R4 R5 R6 R7: word sweep over parity, polarity, encoding, identifier
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] w;
      w = 32'h8000_0001 ^ (k * 32'h1357_9BDF);
      @(negedge clk);
      par_en = k[0]; par_odd = k[1]; man_sel = k[2];
      send_word(w, k[3]);
      wait_frame("R3 sweep");
      ex_clear(); ex_push(1); ex_push(k[3]); ex_word(w, k[0], k[1]);
      check_frame($sformatf("R3 R4 R5 R6 R7 word sweep k=%0d", k));
    end

    // R8: control frame sweep
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      type_e = k[3]; man_sel = k[4];
      ctl_data = k[0]; ctl_cmd = k[1]; ctl_bit4 = k[2]; ctl_ld = 1;
      @(negedge clk);
      ctl_ld = 0;
      wait_frame("R8 sweep");
      ex_clear(); ex_push(1); ex_push(k[0]); ex_push(k[1]);
      if (k[3]) ex_push(k[2]);
      check_frame($sformatf("R8 control sweep k=%0d", k));
    end

    // R9 R1: ordering and ignored requests
    @(negedge clk);
    man_sel = 0; par_en = 1; par_odd = 0; type_e = 1;
    wa = 32'hDEAD_BEEF; wb = 32'h0F0F_3C3C; wc = 32'hFFFF_0000;
    send_word(wa, 0);
    while (!env_o) @(negedge clk);
    ctl_data = 1; ctl_cmd = 0; ctl_bit4 = 1; ctl_ld = 1;
    @(negedge clk);
    ctl_data = 0; ctl_cmd = 1; ctl_bit4 = 0;
    @(negedge clk);
    ctl_ld = 0;
    wait_ready();
    send_word(wb, 1);
    send_word(wc, 0);
    wait_frame("R9 first");
    ex_clear(); ex_push(1); ex_push(0); ex_word(wa, 1, 0);
    check_frame("R9 word not interrupted");
    wait_frame("R9 second");
    ex_clear(); ex_push(1); ex_push(1); ex_push(0); ex_push(1);
    check_frame("R9 control first, second request ignored");
    wait_frame("R9 third");
    ex_clear(); ex_push(1); ex_push(1); ex_word(wb, 1, 0);
    check_frame("R1 R9 held word kept over ignored strobe");
    repeat (200) @(negedge clk);
    check1("R1 ignored strobe made no frame", done_cnt, seen_done);
    check1("R1 latch free after queue drained", ready_o, 1);

    // R10: burst joining
    for (int p = 0; p < 2; p++) begin
      logic [W-1:0] b1, b2, b3;
      b1 = 32'hA5A5_0001 + p; b2 = 32'h0000_FFFF ^ p; b3 = 32'h7E81_24C3 + 3*p;
      @(negedge clk);
      burst = 1; par_en = p[0]; par_odd = 1; man_sel = 0;
      send_word(b1, 0);
      wait_ready();
      send_word(b2, 0);
      wait_ready();
      send_word(b3, 0);
      wait_frame("R10 burst");
      ex_clear(); ex_push(1); ex_push(0);
      ex_word(b1, p[0], 1); ex_word(b2, p[0], 1); ex_word(b3, p[0], 1);
      check_frame($sformatf("R10 burst of three p=%0d", p));
      @(negedge clk);
      burst = 0;
    end

    // R11: FIFO handshake
    begin
      int fk = 0, nchk = 0, rdc = 0;
      @(negedge clk);
      par_en = 1; par_odd = 1; man_sel = 1;
      seen_done = done_cnt;
      fifo_en = 1;
      for (int t = 0; t < 4000 && nchk < 3; t++) begin
        @(posedge clk);
        if (done_cnt != seen_done) begin
          seen_done = done_cnt;
          ex_clear(); ex_push(1); ex_push(nchk[0]); ex_word(fifo_word(nchk), 1, 1);
          check_frame($sformatf("R11 fifo word %0d", nchk));
          nchk++;
        end
        @(negedge clk);
        if (!fifo_rd_n) begin
          rdc++;
          if (fk < 3) begin bus_i = fifo_word(fk); wi_i = fk[0]; end
          fk++;
          if (fk >= 3) fifo_en = 0;
        end
      end
      check1("R11 fifo frames seen", nchk, 3);
      check1("R11 fifo read pulses", rdc, 3);
      check1("R11 read idle after disable", fifo_rd_n, 1);
    end

    // R12: loopback routing
    begin
      int bad_on = 0, bad_off = 0, toggles = 0;
      logic last_b;
      @(negedge clk);
      man_sel = 0;
      send_word(32'h3355_AACC, 0);
      while (!env_o) @(negedge clk);
      loop_en = 1;
      last_b = tx_b_o;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (rx_data_o !== tx_a_o || rx_clk_o !== tx_b_o) bad_on++;
        if (rx_clk_o != last_b) toggles++;
        last_b = rx_clk_o;
      end
      loop_en = 0;
      for (int t = 0; t < 8; t++) begin
        rx_data_i = t[0]; rx_clk_i = t[1];
        @(negedge clk);
        if (rx_data_o !== t[0] || rx_clk_o !== t[1]) bad_off++;
      end
      check1("R12 loopback on mismatches", bad_on, 0);
      check1("R12 loopback clock toggles", toggles, 20);
      check1("R12 loopback off mismatches", bad_off, 0);
      wait_frame("R12 frame");
      ex_clear(); ex_push(1); ex_push(0); ex_word(32'h3355_AACC, 1, 1);
      check_frame("R12 frame during loopback");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule